// File: doc/BRIEF.md
# Conditional Return Dispatch Decoder

This block is the decode step of a small 8-bit accumulator processor. It looks at the fetched opcode and at four status flags (carry, zero, parity/overflow and sign), then picks the next execution state. It also runs the short sequence that pops a return address off the stack. The eight conditional-return opcodes are decoded against the flag that their condition code selects. A return whose condition holds starts a two-read pop sequence, then loads the program counter and moves the stack pointer up by two. A return whose condition fails goes to the same register-to-register pass-through state that a no-op uses. That state writes no register, and the program counter moves on by one, so the following opcode executes normally.

The decode table is built as a set of match entries, each one an opcode match ANDed with a flag term, and the entries are ORed together. The all-zero state code belongs to the prefix state, which swallows the next opcode byte. Every conditional return therefore has an entry in both outcomes, and a gap in the table can never fall through to zero. Conditional jumps and calls are not tested at decode time. They always go to one common state that fetches the 16-bit operand.

Top module: `cond_ret_dispatch`

## Requirements
- R1: Opcodes of the form 11ccc000 are conditional returns, and cc = opcode[5:3] selects the condition: 0 zero clear, 1 zero set, 2 carry clear, 3 carry set, 4 parity clear, 5 parity set, 6 sign clear, 7 sign set. The flag input bits are [0] carry, [1] zero, [2] parity, [3] sign.
- R2: An accepted conditional return whose condition holds sets `exec_state` to RET (3'd2) and raises `busy` for two cycles. In the first busy cycle it reads memory at SP, and in the second at SP+1, with `mem_rd` high in both cycles.
- R3: Two cycles after a taken return is accepted, `pc` equals {byte at SP+1, byte at SP}, SP has grown by 2 and `busy` is low.
- R4: An accepted conditional return whose condition fails sets `exec_state` to R2R (3'd1). It adds 1 to `pc`, leaves SP unchanged and keeps `rf_we` low. An ordinary register opcode such as 0x78 decodes to OTHER (3'd5) with `rf_we` high.
- R5: No conditional return ever decodes to the prefix state PREFIX (3'd0). Only opcode 0xCB does, and 0x00 decodes to R2R.
- R6: After a not-taken return, the next opcode 0xE5 (push) is executed. It decodes to PUSH (3'd4), subtracts 2 from SP and adds 1 to `pc`.
- R7: Conditional jumps (11ccc010) and conditional calls (11ccc100) decode to ADDR16 (3'd3) for every flag value, and add 1 to `pc`.
- R8: After reset, `pc` is 0, SP equals SP_INIT (0x07FF), `exec_state` is R2R, and `busy`, `mem_rd` and `rf_we` are low.
- R9: `op_valid` is ignored while `busy` is high. An opcode offered during the pop sequence leaves `pc`, SP and `exec_state` as the return sets them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode byte is offered this cycle |
| opcode | input | 8 | Fetched opcode byte |
| flags | input | 4 | Status flags {sign, parity, zero, carry} |
| mem_rdata | input | 8 | Stack read data, combinational from mem_addr |
| mem_addr | output | 16 | Stack read address |
| mem_rd | output | 1 | Stack read strobe |
| busy | output | 1 | Pop sequence in progress; opcodes are not accepted |
| exec_state | output | 3 | State chosen for the last accepted opcode |
| rf_we | output | 1 | Register write for the last accepted opcode |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |

## Verification
An opcode is accepted on the clock edge where `op_valid` is high and `busy` is low. `exec_state`, `pc`, SP and `rf_we` then change on that same edge, so the bench samples them at the next falling edge. The two stack reads are combinational from the sequencer state, so the bench checks the first one at the falling edge after acceptance and the second one a full cycle later. The loaded `pc` and the raised SP appear after the second edge following acceptance, and the bench checks them at the falling edge after that. The sweep covers every return condition with all sixteen flag values and follows each not-taken case with a push.

// File: rtl/crd_pkg.sv
package crd_pkg;
  typedef enum logic [2:0] {
    ST_PREFIX = 3'd0,
    ST_R2R    = 3'd1,
    ST_RET    = 3'd2,
    ST_ADDR16 = 3'd3,
    ST_PUSH   = 3'd4,
    ST_OTHER  = 3'd5
  } exec_st_e;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_P = 2;
  localparam int FL_S = 3;
  localparam int NUM_FLAGS = 4;
  localparam int NUM_ENTRIES = 7;

  typedef enum logic [1:0] {SEQ_IDLE = 2'd0, SEQ_LO = 2'd1, SEQ_HI = 2'd2} seq_e;
endpackage

// File: rtl/crd_cond_sel.sv
module crd_cond_sel
  import crd_pkg::*;
(
  input  logic [2:0]           cc,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic                 hold
);
  logic sel_flag;

  always_comb begin
    unique case (cc[2:1])
      2'd0:    sel_flag = flags[FL_Z];
      2'd1:    sel_flag = flags[FL_C];
      2'd2:    sel_flag = flags[FL_P];
      default: sel_flag = flags[FL_S];
    endcase
    // odd codes test the flag set, even codes test it clear
    hold = cc[0] ? sel_flag : ~sel_flag;
  end
endmodule

// File: rtl/crd_decode.sv
module crd_decode
  import crd_pkg::*;
(
  input  logic [7:0]             opcode,
  input  logic                   cond_hold,
  output exec_st_e               nxt,
  output logic                   is_cret,
  output logic [NUM_ENTRIES-1:0] hit
);
  logic     is_cjp, is_ccall, is_nop, is_push, is_cb;
  exec_st_e ent_st [NUM_ENTRIES];
  logic [2:0] acc [NUM_ENTRIES+1];

  always_comb begin
    is_cret  = (opcode[7:6] == 2'b11) && (opcode[2:0] == 3'b000);
    is_cjp   = (opcode[7:6] == 2'b11) && (opcode[2:0] == 3'b010);
    is_ccall = (opcode[7:6] == 2'b11) && (opcode[2:0] == 3'b100);
    is_nop   = (opcode == 8'h00);
    is_push  = (opcode == 8'hE5);
    is_cb    = (opcode == 8'hCB);

    // every conditional return matches exactly one entry in either outcome
    hit[0] = is_cret & cond_hold;
    hit[1] = is_cret & ~cond_hold;
    hit[2] = is_cjp | is_ccall;
    hit[3] = is_nop;
    hit[4] = is_push;
    hit[5] = is_cb;
    hit[6] = ~(is_cret | is_cjp | is_ccall | is_nop | is_push | is_cb);

    ent_st[0] = ST_RET;
    ent_st[1] = ST_R2R;
    ent_st[2] = ST_ADDR16;
    ent_st[3] = ST_R2R;
    ent_st[4] = ST_PUSH;
    ent_st[5] = ST_PREFIX;
    ent_st[6] = ST_OTHER;
  end

  assign acc[0] = 3'd0;
  generate
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_or
      assign acc[i+1] = acc[i] | ({3{hit[i]}} & ent_st[i]);
    end
  endgenerate

  assign nxt = exec_st_e'(acc[NUM_ENTRIES]);
endmodule

// File: rtl/crd_seq.sv
module crd_seq
  import crd_pkg::*;
#(
  parameter int          AW      = 16,
  parameter logic [AW-1:0] SP_INIT = 16'h07FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  exec_st_e      nxt,
  input  logic [7:0]    mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          busy,
  output exec_st_e      exec_state,
  output logic          rf_we,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] sp
);
  seq_e          seq_q, seq_d;
  logic [7:0]    lo_q, lo_d;
  logic [AW-1:0] pc_d, sp_d;
  exec_st_e      st_d;
  logic          we_d;
  logic          st_en;

  always_comb begin
    seq_d = seq_q;
    lo_d  = lo_q;
    pc_d  = pc;
    sp_d  = sp;
    st_d  = exec_state;
    we_d  = rf_we;
    st_en = 1'b0;
    unique case (seq_q)
      SEQ_IDLE: if (accept) begin
        st_en = 1'b1;
        st_d  = nxt;
        we_d  = (nxt == ST_OTHER);
        if (nxt == ST_RET) begin
          seq_d = SEQ_LO;
        end else begin
          pc_d = pc + AW'(1);
          if (nxt == ST_PUSH) sp_d = sp - AW'(2);
        end
      end
      SEQ_LO: begin
        lo_d  = mem_rdata;
        seq_d = SEQ_HI;
      end
      default: begin
        pc_d  = {mem_rdata, lo_q};
        sp_d  = sp + AW'(2);
        seq_d = SEQ_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q      <= SEQ_IDLE;
      lo_q       <= 8'h00;
      pc         <= '0;
      sp         <= SP_INIT;
      exec_state <= ST_R2R;
      rf_we      <= 1'b0;
    end else begin
      seq_q <= seq_d;
      lo_q  <= lo_d;
      pc    <= pc_d;
      sp    <= sp_d;
      if (st_en) begin
        exec_state <= st_d;
        rf_we      <= we_d;
      end
    end
  end

  assign busy     = (seq_q != SEQ_IDLE);
  assign mem_rd   = busy;
  assign mem_addr = (seq_q == SEQ_HI) ? sp + AW'(1) : sp;

  // R3
  pop_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q == SEQ_HI) |=> (sp == $past(sp) + AW'(2)) && !busy);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q == SEQ_LO) |=> $stable(exec_state) && $stable(pc) && busy);
endmodule

// File: rtl/cond_ret_dispatch.sv
module cond_ret_dispatch
  import crd_pkg::*;
#(
  parameter int            AW      = 16,
  parameter logic [AW-1:0] SP_INIT = 16'h07FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [7:0]    opcode,
  input  logic [3:0]    flags,
  input  logic [7:0]    mem_rdata,
  output logic [15:0]   mem_addr,
  output logic          mem_rd,
  output logic          busy,
  output logic [2:0]    exec_state,
  output logic          rf_we,
  output logic [15:0]   pc,
  output logic [15:0]   sp
);
  logic                   hold, is_cret, accept;
  logic [NUM_ENTRIES-1:0] hit;
  exec_st_e               nxt, st_q;

  crd_cond_sel u_sel (.cc(opcode[5:3]), .flags(flags), .hold(hold));

  crd_decode u_dec (
    .opcode(opcode), .cond_hold(hold), .nxt(nxt), .is_cret(is_cret), .hit(hit)
  );

  assign accept = op_valid & ~busy;

  crd_seq #(.AW(AW), .SP_INIT(SP_INIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .nxt(nxt),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .busy(busy), .exec_state(st_q), .rf_we(rf_we), .pc(pc), .sp(sp)
  );

  assign exec_state = st_q;

  // R5
  one_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $onehot(hit));

  // R5
  no_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_cret) |-> (nxt != ST_PREFIX));

  // R4
  not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_cret && !hold) |=> (st_q == ST_R2R) && !rf_we && $stable(sp)
      && (pc == $past(pc) + AW'(1)));

  // R2
  taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_cret && hold) |=> busy && mem_rd && (mem_addr == sp));
endmodule

// File: tb/cond_ret_dispatch_test.sv
module cond_ret_dispatch_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [7:0]  opcode;
  logic [3:0]  flags;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr, pc, sp;
  logic        mem_rd, busy, rf_we;
  logic [2:0]  exec_state;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [15:0] m_pc, m_sp;

  always #2 clk = ~clk;

  cond_ret_dispatch uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode), .flags(flags),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd), .busy(busy),
    .exec_state(exec_state), .rf_we(rf_we), .pc(pc), .sp(sp)
  );

  function automatic logic [7:0] mem_of(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign mem_rdata = mem_of(mem_addr);

  function automatic logic holds(input logic [2:0] cc, input logic [3:0] f);
    logic v;
    case (cc[2:1])
      2'd0: v = f[1];
      2'd1: v = f[0];
      2'd2: v = f[2];
      default: v = f[3];
    endcase
    return cc[0] ? v : ~v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  // offer one opcode, step over the accept edge, sample at the falling edge
  task automatic issue(input logic [7:0] op, input logic [3:0] f);
    opcode   = op;
    flags    = f;
    op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; opcode = 8'h00; flags = 4'h0;
    repeat (3) @(negedge clk);
    // R8
    chk("R8 pc", pc, 16'h0000);
    chk("R8 sp", sp, 16'h07FF);
    chk("R8 state", exec_state, 3'd1);
    chk("R8 busy/rd/we", {busy, mem_rd, rf_we}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    m_pc = 16'h0000; m_sp = 16'h07FF;

    // R1 R2 R3 R4 R6: every condition, every flag value
    for (int cc = 0; cc < 8; cc++) begin
      for (int f = 0; f < 16; f++) begin
        logic [7:0] op;
        op = {2'b11, 3'(cc), 3'b000};
        issue(op, 4'(f));
        if (holds(3'(cc), 4'(f))) begin
          chk("R1 R2 taken state", exec_state, 3'd2);
          chk("R2 busy lo", {busy, mem_rd}, 2'b11);
          chk("R2 read lo addr", mem_addr, m_sp);
          @(negedge clk);
          chk("R2 read hi addr", mem_addr, m_sp + 16'd1);
          @(negedge clk);
          m_pc = {mem_of(m_sp + 16'd1), mem_of(m_sp)};
          m_sp = m_sp + 16'd2;
          chk("R3 pc load", pc, m_pc);
          chk("R3 sp pop", sp, m_sp);
          chk("R3 busy low", busy, 1'b0);
        end else begin
          m_pc = m_pc + 16'd1;
          chk("R1 R4 not taken state", exec_state, 3'd1);
          chk("R4 pc+1", pc, m_pc);
          chk("R4 sp kept", sp, m_sp);
          chk("R4 no write", rf_we, 1'b0);
          chk("R4 not busy", busy, 1'b0);
          issue(8'hE5, 4'(f));
          m_pc = m_pc + 16'd1;
          m_sp = m_sp - 16'd2;
          chk("R6 push state", exec_state, 3'd4);
          chk("R6 push sp", sp, m_sp);
          chk("R6 push pc", pc, m_pc);
        end
      end
    end

    // R7: conditional jump and call never tested at decode
    for (int cc = 0; cc < 8; cc++) begin
      for (int f = 0; f < 16; f += 5) begin
        issue({2'b11, 3'(cc), 3'b010}, 4'(f));
        m_pc = m_pc + 16'd1;
        chk("R7 jp state", exec_state, 3'd3);
        chk("R7 jp pc", pc, m_pc);
        issue({2'b11, 3'(cc), 3'b100}, 4'(f));
        m_pc = m_pc + 16'd1;
        chk("R7 call state", exec_state, 3'd3);
        chk("R7 call pc", pc, m_pc);
      end
    end

    // R5 and R4 write flag for an ordinary opcode
    issue(8'hCB, 4'h0);
    m_pc = m_pc + 16'd1;
    chk("R5 prefix only for CB", exec_state, 3'd0);
    issue(8'h00, 4'h0);
    m_pc = m_pc + 16'd1;
    chk("R5 nop to r2r", exec_state, 3'd1);
    issue(8'h78, 4'h0);
    m_pc = m_pc + 16'd1;
    chk("R4 other state", exec_state, 3'd5);
    chk("R4 other writes", rf_we, 1'b1);
    chk("R4 pc track", pc, m_pc);

    // R9: push offered during the pop sequence is ignored
    issue(8'hC8, 4'b0010);
    opcode = 8'hE5; op_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    m_pc = {mem_of(m_sp + 16'd1), mem_of(m_sp)};
    m_sp = m_sp + 16'd2;
    chk("R9 pc", pc, m_pc);
    chk("R9 sp", sp, m_sp);
    chk("R9 state", exec_state, 3'd2);
    @(negedge clk);
    chk("R9 sp after", sp, m_sp);

    summary();
  end
endmodule